// File: doc/BRIEF.md
# Multi-channel reloadable down-counting timer

A bank of independent down-counting timer channels behind a simple word-addressed register bus. Each channel holds a configuration word, a running counter that software may only read, and a fixed count that software writes. The configuration chooses what makes the counter step: every clock, a slow reference strobe supplied from outside, or nothing at all. It also chooses whether the counter restarts from the fixed count once it reaches zero. When a step takes a channel from one to zero, a sticky status flag is set. Where that flag is enabled it drives a single combined interrupt line.

Every configuration word, and the one shared control word, has two alias addresses. One ORs the written ones into the register and the other clears them, so software never needs a read-modify-write sequence to flip one bit. Software can make a fixed-count write load the running counter at once, which suits one-shot event programming. A channel left free-running with reload gives a continuous time base. Inverting its count on readout gives an up-counting value. A read-only word reports the block's major version.

Top module: `dct_timer_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The version word at 0x120 reads 0x02000000, which is major version 2 in bits [31:24].
- R2: With tick select (config bits [3:0]) equal to 0xF, a nonzero running count drops by one on every clock. Channel n has its configuration at 0x20+n*0x40, its running count at 0x30+n*0x40 and its fixed count at 0x40+n*0x40.
- R3: With tick select 0xB, the count drops only in cycles where `slow_tick` is high. Any select value other than 0xB or 0xF holds the count.
- R4: A write to the fixed count always stores the value. If the update bit (config bit 7) is set, the write also loads the running count in the same edge, and that load takes priority over a tick.
- R5: With the reload bit (config bit 6) clear, a count of zero stays at zero on later ticks.
- R6: With the reload bit set, a tick while the count is zero loads the stored fixed count.
- R7: The status flag (config bit 15) sets when a tick, without a concurrent load, moves the count from 1 to 0. It stays set until a 1 is written to bit 15 at the clear alias. If a set and a clear fall in the same cycle, the set wins.
- R8: Writing a configuration word at its base address replaces bits [3:0], 6, 7 and 14, and leaves the status flag alone. The set alias at base+0x4 ORs in the written ones. The clear alias at base+0x8 clears the written ones. All other bits read as zero.
- R9: `irq` is high exactly when some channel has both its status flag and its enable bit (config bit 14) set.
- R10: Writes to the running count, to the version word or to unmapped offsets change nothing. Reads of unmapped offsets, including the alias addresses, return zero.
- R11: The shared control word at 0x00 is a 32-bit read/write register with a set alias at 0x04 and a clear alias at 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | One-cycle strobe from the slow reference |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets five boundaries. A clear that lands in the same cycle as the 1-to-0 step must leave the flag set; a design that gives the clear priority would lose that event. A base write must not disturb a pending flag; a design that copied bit 15 would drop or fake interrupts. At zero, a reloading channel must take the fixed count and a non-reloading one must hold; an off-by-one here either skips the zero cycle or wraps to all ones. Fixed-count writes with and without the update bit, and writes aimed at the read-only count and at unmapped addresses, expose a decoder that is too loose or a load that ignores its enable bit.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int DW        = 32;
    localparam int CH_STRIDE = 'h40;
    localparam int SHR_ADDR  = 'h00;
    localparam int CTRL_BASE = 'h20;
    localparam int CNT_BASE  = 'h30;
    localparam int FIX_BASE  = 'h40;
    localparam int SET_OFS   = 'h4;
    localparam int CLR_OFS   = 'h8;
    localparam int VER_ADDR  = 'h120;

    localparam logic [7:0]    VER_MAJOR = 8'd2;
    localparam logic [DW-1:0] VER_WORD  = {VER_MAJOR, 24'd0};

    localparam logic [3:0] SEL_EVERY = 4'hF;
    localparam logic [3:0] SEL_SLOW  = 4'hB;

    localparam int B_RELOAD = 6;
    localparam int B_UPDATE = 7;
    localparam int B_IEN    = 14;
    localparam int B_IST    = 15;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_BASE,
        WR_SET,
        WR_CLR
    } wr_kind_e;

    typedef struct packed {
        logic [3:0] sel;
        logic       reload;
        logic       update;
        logic       ien;
    } chan_cfg_t;

    function automatic logic [DW-1:0] cfg_to_word(chan_cfg_t c, logic ist);
        logic [DW-1:0] w;
        w           = '0;
        w[3:0]      = c.sel;
        w[B_RELOAD] = c.reload;
        w[B_UPDATE] = c.update;
        w[B_IEN]    = c.ien;
        w[B_IST]    = ist;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(logic [DW-1:0] w);
        chan_cfg_t c;
        c.sel    = w[3:0];
        c.reload = w[B_RELOAD];
        c.update = w[B_UPDATE];
        c.ien    = w[B_IEN];
        return c;
    endfunction

    function automatic logic [DW-1:0] apply_write(wr_kind_e k, logic [DW-1:0] old,
                                                  logic [DW-1:0] wd);
        case (k)
            WR_BASE: return wd;
            WR_SET:  return old | wd;
            WR_CLR:  return old & ~wd;
            default: return old;
        endcase
    endfunction

endpackage

// File: rtl/dct_regdec.sv
module dct_regdec
    import dct_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 12
) (
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    output wr_kind_e              shr_kind,
    output wr_kind_e [N_CH-1:0]   ctl_kind,
    output logic     [N_CH-1:0]   fix_we
);

    function automatic wr_kind_e kind_at(logic we, logic [AW-1:0] a, int base);
        if (!we)                          return WR_NONE;
        if (a == AW'(base))               return WR_BASE;
        if (a == AW'(base + SET_OFS))     return WR_SET;
        if (a == AW'(base + CLR_OFS))     return WR_CLR;
        return WR_NONE;
    endfunction

    assign shr_kind = kind_at(bus_we, bus_addr, SHR_ADDR);

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        localparam int CB = CTRL_BASE + i * CH_STRIDE;
        localparam int FB = FIX_BASE + i * CH_STRIDE;
        assign ctl_kind[i] = kind_at(bus_we, bus_addr, CB);
        assign fix_we[i]   = bus_we && (bus_addr == AW'(FB));
    end

endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_kind_e         ctl_kind,
    input  logic             fix_we,
    input  logic [DW-1:0]    wdata,
    input  logic             slow_tick,
    output logic [DW-1:0]    ctrl_word,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] fix_q,
    output logic             tick,
    output logic             load,
    output logic             ist_q,
    output logic             ist_clr,
    output logic             irq_o
);

    chan_cfg_t cfg_q;
    logic      ist_set;

    always_comb begin
        case (cfg_q.sel)
            SEL_EVERY: tick = 1'b1;
            SEL_SLOW:  tick = slow_tick;
            default:   tick = 1'b0;
        endcase
    end

    assign load      = fix_we && cfg_q.update;
    assign ist_set   = tick && !load && (cnt_q == CNT_W'(1));
    assign ist_clr   = (ctl_kind == WR_CLR) && wdata[B_IST];
    assign ctrl_word = cfg_to_word(cfg_q, ist_q);
    assign irq_o     = ist_q && cfg_q.ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ist_q <= 1'b0;
            cnt_q <= '0;
            fix_q <= '0;
        end else begin
            if (ctl_kind != WR_NONE)
                cfg_q <= word_to_cfg(apply_write(ctl_kind, cfg_to_word(cfg_q, 1'b0), wdata));
            if (fix_we)
                fix_q <= wdata[CNT_W-1:0];
            if (load)
                cnt_q <= wdata[CNT_W-1:0];
            else if (tick) begin
                if (cnt_q != '0)
                    cnt_q <= cnt_q - CNT_W'(1);
                else if (cfg_q.reload)
                    cnt_q <= fix_q;
            end
            if (ist_set)
                ist_q <= 1'b1;
            else if (ist_clr)
                ist_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dct_rdmux.sv
module dct_rdmux
    import dct_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int AW    = 12,
    parameter int CNT_W = 32
) (
    input  logic [AW-1:0]                 bus_addr,
    input  logic [DW-1:0]                 shr_word,
    input  logic [N_CH-1:0][DW-1:0]       ctrl_w,
    input  logic [N_CH-1:0][CNT_W-1:0]    cnt_v,
    input  logic [N_CH-1:0][CNT_W-1:0]    fix_v,
    output logic [DW-1:0]                 rdata
);

    always_comb begin
        rdata = '0;
        if (bus_addr == AW'(SHR_ADDR))
            rdata = shr_word;
        if (bus_addr == AW'(VER_ADDR))
            rdata = VER_WORD;
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == AW'(CTRL_BASE + i * CH_STRIDE))
                rdata = ctrl_w[i];
            if (bus_addr == AW'(CNT_BASE + i * CH_STRIDE))
                rdata = DW'(cnt_v[i]);
            if (bus_addr == AW'(FIX_BASE + i * CH_STRIDE))
                rdata = DW'(fix_v[i]);
        end
    end

endmodule

// File: rtl/dct_timer_bank.sv
module dct_timer_bank
    import dct_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int AW    = 12,
    parameter int CNT_W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          slow_tick,
    output logic          irq
);

    wr_kind_e                   shr_kind;
    wr_kind_e [N_CH-1:0]        ctl_kind;
    logic     [N_CH-1:0]        fix_we;
    logic     [DW-1:0]          shr_q;
    logic [N_CH-1:0][DW-1:0]    ctrl_w;
    logic [N_CH-1:0][CNT_W-1:0] cnt_v;
    logic [N_CH-1:0][CNT_W-1:0] fix_v;
    logic [N_CH-1:0]            tick_v;
    logic [N_CH-1:0]            load_v;
    logic [N_CH-1:0]            ist_v;
    logic [N_CH-1:0]            ist_clr_v;
    logic [N_CH-1:0]            irq_v;
    logic [N_CH-1:0]            reload_v;
    logic [N_CH-1:0]            ien_v;

    dct_regdec #(.N_CH(N_CH), .AW(AW)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .shr_kind (shr_kind),
        .ctl_kind (ctl_kind),
        .fix_we   (fix_we)
    );

    always_ff @(posedge clk) begin
        if (rst)
            shr_q <= '0;
        else if (shr_kind != WR_NONE)
            shr_q <= apply_write(shr_kind, shr_q, bus_wdata);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dct_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .ctl_kind  (ctl_kind[i]),
            .fix_we    (fix_we[i]),
            .wdata     (bus_wdata),
            .slow_tick (slow_tick),
            .ctrl_word (ctrl_w[i]),
            .cnt_q     (cnt_v[i]),
            .fix_q     (fix_v[i]),
            .tick      (tick_v[i]),
            .load      (load_v[i]),
            .ist_q     (ist_v[i]),
            .ist_clr   (ist_clr_v[i]),
            .irq_o     (irq_v[i])
        );
        assign reload_v[i] = ctrl_w[i][B_RELOAD];
        assign ien_v[i]    = ctrl_w[i][B_IEN];
    end

    assign irq = |irq_v;

    dct_rdmux #(.N_CH(N_CH), .AW(AW), .CNT_W(CNT_W)) u_rd (
        .bus_addr (bus_addr),
        .shr_word (shr_q),
        .ctrl_w   (ctrl_w),
        .cnt_v    (cnt_v),
        .fix_v    (fix_v),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/dct_timer_bank_chk.sv
module dct_timer_bank_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       irq,
    input logic [N_CH-1:0][CNT_W-1:0] cnt,
    input logic [N_CH-1:0][CNT_W-1:0] fix,
    input logic [N_CH-1:0]            tick,
    input logic [N_CH-1:0]            load,
    input logic [N_CH-1:0]            ist,
    input logic [N_CH-1:0]            ist_clr,
    input logic [N_CH-1:0]            reload,
    input logic [N_CH-1:0]            ien
);

    for (genvar i = 0; i < N_CH; i++) begin : g_p
        p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
            (tick[i] && !load[i] && cnt[i] != '0) |=> cnt[i] == $past(cnt[i]) - CNT_W'(1));

        p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
            (!tick[i] && !load[i]) |=> $stable(cnt[i]));

        p_load_fixed_r4: assert property (@(posedge clk) disable iff (rst)
            load[i] |=> cnt[i] == fix[i]);

        p_stop_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (tick[i] && !load[i] && cnt[i] == '0 && !reload[i]) |=> cnt[i] == '0);

        p_reload_r6: assert property (@(posedge clk) disable iff (rst)
            (tick[i] && !load[i] && cnt[i] == '0 && reload[i]) |=> cnt[i] == $past(fix[i]));

        p_sticky_flag_r7: assert property (@(posedge clk) disable iff (rst)
            (ist[i] && !ist_clr[i]) |=> ist[i]);

        p_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(ist[i]) |-> $past(cnt[i]) == CNT_W'(1));
    end

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(ist & ien)));

endmodule

bind dct_timer_bank dct_timer_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .cnt     (cnt_v),
    .fix     (fix_v),
    .tick    (tick_v),
    .load    (load_v),
    .ist     (ist_v),
    .ist_clr (ist_clr_v),
    .reload  (reload_v),
    .ien     (ien_v)
);

// File: tb/dct_timer_bank_bench.sv
module dct_timer_bank_bench;

    localparam int CLK_P = 10;
    localparam int NC    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic        slow = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #(CLK_P / 2) clk = ~clk;

    dct_timer_bank u_dct_timer_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .slow_tick (slow),
        .irq       (irq)
    );

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    logic [3:0]  m_sel [NC];
    bit          m_rel [NC];
    bit          m_upd [NC];
    bit          m_ien [NC];
    bit          m_ist [NC];
    logic [31:0] m_cnt [NC];
    logic [31:0] m_fix [NC];
    logic [31:0] m_shr;

    function automatic logic [31:0] m_ctrl(int i);
        return {16'd0, m_ist[i], m_ien[i], 6'd0, m_upd[i], m_rel[i], 2'd0, m_sel[i]};
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a == 12'h000) return m_shr;
        if (a == 12'h120) return 32'h0200_0000;
        for (int i = 0; i < NC; i++) begin
            if (a == 12'(32'h20 + i * 64)) return m_ctrl(i);
            if (a == 12'(32'h30 + i * 64)) return m_cnt[i];
            if (a == 12'(32'h40 + i * 64)) return m_fix[i];
        end
        return 32'd0;
    endfunction

    function automatic bit m_irq();
        bit r = 1'b0;
        for (int i = 0; i < NC; i++) r = r | (m_ist[i] & m_ien[i]);
        return r;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NC; i++) begin
            m_sel[i] = '0; m_rel[i] = 0; m_upd[i] = 0; m_ien[i] = 0; m_ist[i] = 0;
            m_cnt[i] = '0; m_fix[i] = '0;
        end
        m_shr = '0;
    endtask

    task automatic m_step();
        if (we && addr == 12'h000) m_shr = wdata;
        else if (we && addr == 12'h004) m_shr = m_shr | wdata;
        else if (we && addr == 12'h008) m_shr = m_shr & ~wdata;
        for (int i = 0; i < NC; i++) begin
            int          b  = 32'h20 + i * 64;
            bit          tk = (m_sel[i] == 4'hF) || (m_sel[i] == 4'hB && slow);
            bit          ld = we && addr == 12'(b + 32'h20) && m_upd[i];
            logic [31:0] nc = m_cnt[i];
            bit          ni = m_ist[i];
            logic [31:0] w  = {16'd0, 1'b0, m_ien[i], 6'd0, m_upd[i], m_rel[i], 2'd0, m_sel[i]};
            if (ld) nc = wdata;
            else if (tk) begin
                if (m_cnt[i] != 0) nc = m_cnt[i] - 1;
                else if (m_rel[i]) nc = m_fix[i];
            end
            if (tk && !ld && m_cnt[i] == 1) ni = 1'b1;
            else if (we && addr == 12'(b + 8) && wdata[15]) ni = 1'b0;
            if (we && addr == 12'(b)) w = wdata;
            else if (we && addr == 12'(b + 4)) w = w | wdata;
            else if (we && addr == 12'(b + 8)) w = w & ~wdata;
            if (we && addr == 12'(b + 32'h20)) m_fix[i] = wdata;
            m_cnt[i] = nc;
            m_ist[i] = ni;
            m_sel[i] = w[3:0];
            m_rel[i] = w[6];
            m_upd[i] = w[7];
            m_ien[i] = w[14];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one bus cycle: drive, compare outputs against the model, advance the model
    task automatic cyc(input bit w, input logic [11:0] a, input logic [31:0] d,
                       input bit s, input string tag);
        @(negedge clk);
        we = w; addr = a; wdata = d; slow = s;
        #1;
        check(tag, rdata, m_read(a));
        check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq()});
        if (rst) m_reset();
        else     m_step();
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1'b0, a, 32'd0, 1'b0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, tag);
    endtask

    bit finished = 1'b0;

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        rst = 1'b1;
        for (int k = 0; k < 3; k++) rd(12'h020, "R1 in reset");
        rst = 1'b0;

        // R1: reset values and version word
        rd(12'h000, "R1 shared");
        rd(12'h020, "R1 ctrl0");
        rd(12'h030, "R1 cnt0");
        rd(12'h100, "R1 fix3");
        rd(12'h120, "R1 version");
        check("R1 version literal", rdata, 32'h0200_0000);

        // R8: base write then set alias for enable
        wr(12'h020, 32'h0000_0080, "R8 base write");
        wr(12'h024, 32'h0000_4000, "R8 set alias");
        rd(12'h020, "R8 ctrl0 readback");
        check("R8 ctrl0 literal", rdata, 32'h0000_4080);

        // R4: fixed count with update loads running count
        wr(12'h040, 32'd5, "R4 fix0 with update");
        rd(12'h030, "R4 cnt0 loaded");
        check("R4 cnt0 literal", rdata, 32'd5);
        wr(12'h060, 32'h0000_0000, "R4 ch1 no update");
        wr(12'h080, 32'd7, "R4 fix1 store only");
        rd(12'h070, "R4 cnt1 unchanged");
        rd(12'h080, "R4 fix1 stored");

        // R2/R7/R9/R5: run ch0 every clock to zero
        wr(12'h024, 32'h0000_000F, "R2 select every clock");
        for (int k = 0; k < 8; k++) rd(12'h030, "R2 R5 cnt0 run");
        rd(12'h020, "R7 flag set");
        check("R9 irq with enable", {31'd0, irq}, 32'd1);
        for (int k = 0; k < 4; k++) rd(12'h030, "R5 stays zero");

        // R8: base write keeps the status flag
        wr(12'h020, 32'h0000_4000, "R8 base write keeps flag");
        rd(12'h020, "R8 flag kept");
        // R9: disabling enable drops irq, flag stays
        wr(12'h028, 32'h0000_4000, "R9 clear enable");
        rd(12'h020, "R9 flag without enable");
        check("R9 irq low", {31'd0, irq}, 32'd0);
        wr(12'h024, 32'h0000_4000, "R9 re-enable");
        // R7: clear through alias
        wr(12'h028, 32'h0000_8000, "R7 clear flag");
        rd(12'h020, "R7 flag cleared");
        check("R7 flag literal", rdata & 32'h8000, 32'd0);

        // R6: ch1 reload every clock
        wr(12'h060, 32'h0000_40CF, "R6 ch1 cfg");
        wr(12'h080, 32'd3, "R6 fix1");
        for (int k = 0; k < 12; k++) rd(12'h070, "R6 cnt1 reload");

        // R3: ch2 on slow strobe, ch3 with other select
        wr(12'h0A0, 32'h0000_008B, "R3 ch2 cfg");
        wr(12'h0C0, 32'd10, "R3 fix2");
        for (int k = 0; k < 20; k++) cyc(1'b0, 12'h0B0, 32'd0, (k % 3) == 0, "R3 cnt2 slow");
        wr(12'h0E0, 32'h0000_0085, "R3 ch3 cfg other select");
        wr(12'h100, 32'd9, "R3 fix3");
        for (int k = 0; k < 5; k++) cyc(1'b0, 12'h0F0, 32'd0, 1'b1, "R3 cnt3 held");

        // R7: clear in the same cycle as the 1-to-0 step
        wr(12'h0E0, 32'h0000_408F, "R7 ch3 every clock");
        wr(12'h100, 32'd2, "R7 fix3 load");
        rd(12'h0F0, "R7 cnt3 two");
        wr(12'h0E8, 32'h0000_8000, "R7 clear at step");
        rd(12'h0E0, "R7 set wins");
        check("R7 set wins literal", rdata & 32'h8000, 32'h8000);

        // R10: read-only count and unmapped addresses
        wr(12'h030, 32'h0000_0055, "R10 write running count");
        rd(12'h030, "R10 cnt0 unchanged");
        wr(12'h010, 32'hFFFF_FFFF, "R10 unmapped write");
        rd(12'h010, "R10 unmapped read");
        rd(12'h024, "R10 alias read");
        wr(12'h120, 32'h1234_5678, "R10 version write");
        rd(12'h120, "R10 version kept");

        // R11: shared control word and its aliases
        wr(12'h000, 32'h0000_A5A5, "R11 shared write");
        wr(12'h004, 32'h0000_0F00, "R11 shared set");
        wr(12'h008, 32'h0000_00A0, "R11 shared clear");
        rd(12'h000, "R11 shared readback");
        check("R11 shared literal", rdata, 32'h0000_AF05);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule